// File: doc/BRIEF.md
# In-Order Micro-Op Issue Controller

This block decides, one clock cycle at a time, which instructions leave an in-order front-end queue for execution. Each cycle has a budget of `ISSUE_W` micro-ops. The front end offers up to `LANES` instructions in program order. Each offer carries a micro-op count and two group flags: one that opens an issue group and one that closes it. The controller takes the longest in-order prefix that the cycle's budget allows. It reports which lanes were taken, how many micro-ops went out this cycle, and a running total of issued micro-ops.

An instruction may need more micro-ops than a whole cycle can hold. Such an instruction is still taken, as long as at least one slot of budget is left. Its first micro-ops go out at once. The rest is kept as a carry-over remainder, and that remainder uses the budget of the following cycles before anything else can issue. No instruction can therefore block the stage forever.

An external stall input parks the next offered instruction in a single hold register. That instruction issues once the stall drops. A flag reports while a carry-over remainder or a held instruction is pending.

Top module: `uop_issue_ctrl`

## Requirements
- R1: At the start of every cycle the budget is refilled to `ISSUE_W`. The micro-ops reported on `cyc_uops` in one cycle never exceed `ISSUE_W`.
- R2: Lanes are taken as an in-order prefix: lane i+1 is taken only if lane i is taken. An instruction whose count is at most `ISSUE_W` issues only if the remaining budget is at least its count. `fe_take` bit i belongs to lane i, and the count of lane i sits in `fe_uops[i*4 +: 4]`. A valid count is never zero.
- R3: An instruction whose count exceeds `ISSUE_W` is taken whenever the remaining budget is at least 1. It issues as many micro-ops as the budget holds. The rest (count minus budget) appears on `carry_pend` after the clock edge, and nothing more issues that cycle.
- R4: A pending carry-over is serviced before any held or new instruction. If it exceeds `ISSUE_W`, exactly `ISSUE_W` of it issues, `carry_pend` drops by `ISSUE_W`, and nothing else issues.
- R5: When the pending carry-over fits, it completes, and the budget left for that cycle is `ISSUE_W` minus the remainder. If the instruction closes a group, the budget left is zero instead.
- R6: An instruction that closes a group and issues completely in one cycle leaves no budget for the rest of that cycle.
- R7: An instruction that opens a group issues only as the first issue of its cycle. The completion of a carry-over counts as an earlier issue.
- R8: While `stall_i` is high, no lane issues. If the stage can take an instruction, a valid lane 0 is taken into the hold register. The held instruction issues after any carry-over, under the same budget rules, in the first cycle with `stall_i` low. Later lanes may follow it in that same cycle.
- R9: No lane is taken while a held instruction remains or while a carry-over is still pending at the end of the current cycle's service. A held instruction and a carry-over never coexist.
- R10: `busy` is high exactly when, at the start of the cycle, a carry-over remainder or a held instruction is pending.
- R11: `total_uops` is 0 after reset and adds `cyc_uops` at every clock edge, wrapping at its width.
- R12: With `ISSUE_W` = 2, a 3-micro-op instruction issues 2 micro-ops in its cycle. In the next cycle it issues 1 micro-op, and a following 1-micro-op instruction is taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | External stall; parks the next instruction |
| fe_valid | input | LANES | Lane holds an instruction |
| fe_first | input | LANES | Instruction opens an issue group |
| fe_last | input | LANES | Instruction closes an issue group |
| fe_uops | input | LANES*4 | Micro-op count per lane, lane i at bits i*4 upward |
| fe_take | output | LANES | Lane consumed this cycle (issued or parked) |
| iss_lane | output | LANES | Lane issued this cycle |
| held_issued | output | 1 | Held instruction issued this cycle |
| carry_serviced | output | 1 | A carry-over remainder was serviced this cycle |
| cyc_uops | output | clog2(ISSUE_W+1) | Micro-ops issued this cycle |
| carry_pend | output | 4 | Carry-over remainder pending at cycle start |
| total_uops | output | CNT_W | Running count of issued micro-ops |
| busy | output | 1 | Carry-over or held instruction pending |

## Verification
Assertions check the cycle cap, the in-order prefix shape of `fe_take`, and the absence of lane issue under stall on every cycle. They also check the mutual exclusion of hold and carry-over, the placement of group openers, the drain step of a long remainder and the counter update. Whether the exact budget left after a carry-over completes or a group closes is correct, and whether the right lanes are taken, can only be shown by the bench. The bench compares against an arithmetic model over exhaustive lane pairs and long pseudo-random runs with stalls.

// File: rtl/ioi_pkg.sv
package ioi_pkg;
    parameter int UOP_W = 4;

    typedef logic [UOP_W-1:0] uop_t;

    typedef struct packed {
        uop_t uops;
        logic grp_first;
        logic grp_last;
    } instr_t;

    typedef struct packed {
        logic go;
        uop_t issued;
        uop_t rem;
        uop_t budget;
        logic first;
    } step_res_t;
endpackage

// File: rtl/ioi_step.sv
module ioi_step import ioi_pkg::*; #(
    parameter int ISSUE_W = 2
) (
    input  logic      en,
    input  instr_t    ins,
    input  uop_t      budget_in,
    input  logic      first_in,
    output step_res_t res
);
    localparam uop_t WID = uop_t'(ISSUE_W);

    logic oversize;
    logic room;

    always_comb begin
        oversize = ins.uops > WID;
        room     = oversize ? (budget_in != '0) : (budget_in >= ins.uops);
        res.go     = 1'b0;
        res.issued = '0;
        res.rem    = '0;
        res.budget = budget_in;
        res.first  = first_in;
        if (en && room && (first_in || !ins.grp_first)) begin
            res.go    = 1'b1;
            res.first = 1'b0;
            if (ins.uops > budget_in) begin
                res.issued = budget_in;
                res.rem    = ins.uops - budget_in;
                res.budget = '0;
            end else begin
                res.issued = ins.uops;
                res.budget = ins.grp_last ? '0 : budget_in - ins.uops;
            end
        end
    end
endmodule

// File: rtl/ioi_carry.sv
module ioi_carry import ioi_pkg::*; #(
    parameter int ISSUE_W = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  uop_t load_cnt,
    input  logic load_last,
    output logic active,
    output uop_t used,
    output uop_t budget_out,
    output logic first_out,
    output uop_t left,
    output uop_t cnt_q
);
    localparam uop_t WID = uop_t'(ISSUE_W);

    logic last_q;

    always_comb begin
        active     = cnt_q != '0;
        first_out  = !active;
        used       = '0;
        left       = '0;
        budget_out = WID;
        if (active) begin
            if (cnt_q > WID) begin
                used       = WID;
                left       = cnt_q - WID;
                budget_out = '0;
            end else begin
                used       = cnt_q;
                budget_out = last_q ? '0 : WID - cnt_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            last_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= load_cnt;
            last_q <= load_last;
        end else begin
            cnt_q  <= left;
        end
    end

    assert_no_clobber_R4: assert property (@(posedge clk) disable iff (rst)
        load |-> (left == '0));

    assert_drain_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt_q > WID) |=> (cnt_q == $past(cnt_q) - WID));
endmodule

// File: rtl/ioi_hold.sv
module ioi_hold import ioi_pkg::*; (
    input  logic   clk,
    input  logic   rst,
    input  logic   capture,
    input  instr_t cap_ins,
    input  logic   release_i,
    output logic   vld_q,
    output instr_t ins_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            ins_q <= '0;
        end else if (capture) begin
            vld_q <= 1'b1;
            ins_q <= cap_ins;
        end else if (release_i) begin
            vld_q <= 1'b0;
        end
    end

    assert_single_hold_R8: assert property (@(posedge clk) disable iff (rst)
        capture |-> !vld_q);
endmodule

// File: rtl/uop_issue_ctrl.sv
module uop_issue_ctrl import ioi_pkg::*; #(
    parameter int ISSUE_W = 2,
    parameter int LANES   = 2,
    parameter int CNT_W   = 16,
    localparam int CW     = $clog2(ISSUE_W + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   stall_i,
    input  logic [LANES-1:0]       fe_valid,
    input  logic [LANES-1:0]       fe_first,
    input  logic [LANES-1:0]       fe_last,
    input  logic [LANES*UOP_W-1:0] fe_uops,
    output logic [LANES-1:0]       fe_take,
    output logic [LANES-1:0]       iss_lane,
    output logic                   held_issued,
    output logic                   carry_serviced,
    output logic [CW-1:0]          cyc_uops,
    output logic [UOP_W-1:0]       carry_pend,
    output logic [CNT_W-1:0]       total_uops,
    output logic                   busy
);
    localparam uop_t WID = uop_t'(ISSUE_W);

    logic      c_active, c_first, c_load, c_load_last;
    uop_t      c_used, c_bud, c_left, c_q, c_load_cnt;
    logic      h_vld, capture, lanes_en;
    instr_t    h_ins;
    step_res_t s_res;
    uop_t      cyc_sum;
    logic [CNT_W-1:0] total_q;

    instr_t    lane_ins [LANES];
    step_res_t l_res    [LANES];
    uop_t      bud      [LANES+1];
    logic      fst      [LANES+1];
    logic      chain_ok [LANES+1];

    ioi_carry #(.ISSUE_W(ISSUE_W)) u_carry (
        .clk(clk), .rst(rst),
        .load(c_load), .load_cnt(c_load_cnt), .load_last(c_load_last),
        .active(c_active), .used(c_used), .budget_out(c_bud),
        .first_out(c_first), .left(c_left), .cnt_q(c_q)
    );

    ioi_hold u_hold (
        .clk(clk), .rst(rst),
        .capture(capture), .cap_ins(lane_ins[0]), .release_i(s_res.go),
        .vld_q(h_vld), .ins_q(h_ins)
    );

    ioi_step #(.ISSUE_W(ISSUE_W)) u_held_step (
        .en(h_vld && !stall_i && (c_left == '0)),
        .ins(h_ins), .budget_in(c_bud), .first_in(c_first), .res(s_res)
    );

    assign lanes_en    = (c_left == '0) && (!h_vld || s_res.go) && (s_res.rem == '0);
    assign capture     = stall_i && lanes_en && fe_valid[0];
    assign bud[0]      = s_res.budget;
    assign fst[0]      = s_res.first;
    assign chain_ok[0] = 1'b1;

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_lane
            assign lane_ins[gi].uops      = fe_uops[gi*UOP_W +: UOP_W];
            assign lane_ins[gi].grp_first = fe_first[gi];
            assign lane_ins[gi].grp_last  = fe_last[gi];

            ioi_step #(.ISSUE_W(ISSUE_W)) u_step (
                .en(fe_valid[gi] && lanes_en && !stall_i && chain_ok[gi]),
                .ins(lane_ins[gi]), .budget_in(bud[gi]), .first_in(fst[gi]),
                .res(l_res[gi])
            );

            assign bud[gi+1]      = l_res[gi].budget;
            assign fst[gi+1]      = l_res[gi].first;
            assign chain_ok[gi+1] = l_res[gi].go;
            assign iss_lane[gi]   = l_res[gi].go;
            assign fe_take[gi]    = l_res[gi].go || ((gi == 0) && capture);
        end
    endgenerate

    always_comb begin
        c_load      = 1'b0;
        c_load_cnt  = '0;
        c_load_last = 1'b0;
        if (s_res.rem != '0) begin
            c_load      = 1'b1;
            c_load_cnt  = s_res.rem;
            c_load_last = h_ins.grp_last;
        end
        for (int i = 0; i < LANES; i++) begin
            if (l_res[i].rem != '0) begin
                c_load      = 1'b1;
                c_load_cnt  = l_res[i].rem;
                c_load_last = lane_ins[i].grp_last;
            end
        end
    end

    always_comb begin
        cyc_sum = c_used + s_res.issued;
        for (int i = 0; i < LANES; i++) begin
            cyc_sum = cyc_sum + l_res[i].issued;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) total_q <= '0;
        else     total_q <= total_q + CNT_W'(cyc_uops);
    end

    assign cyc_uops       = CW'(cyc_sum);
    assign held_issued    = s_res.go;
    assign carry_serviced = c_active;
    assign carry_pend     = c_q;
    assign total_uops     = total_q;
    assign busy           = (c_q != '0) || h_vld;

    assert_width_cap_R1: assert property (@(posedge clk) disable iff (rst)
        cyc_sum <= WID);

    assert_stall_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        stall_i |-> (iss_lane == '0));

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(h_vld && (c_q != '0)));

    assert_no_intake_R9: assert property (@(posedge clk) disable iff (rst)
        (c_q > WID) |-> (fe_take == '0));

    assert_opener_lane0_R7: assert property (@(posedge clk) disable iff (rst)
        (iss_lane[0] && fe_first[0]) |-> (!c_active && !held_issued));

    assert_count_R11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (total_uops == $past(total_uops) + CNT_W'($past(cyc_uops))));

    generate
        for (gi = 0; gi < LANES; gi++) begin : g_chk
            assert_nonzero_uops_R2: assert property (@(posedge clk) disable iff (rst)
                fe_valid[gi] |-> (fe_uops[gi*UOP_W +: UOP_W] != '0));
            if (gi > 0) begin : g_tail
                assert_prefix_R2: assert property (@(posedge clk) disable iff (rst)
                    fe_take[gi] |-> fe_take[gi-1]);
                assert_opener_tail_R7: assert property (@(posedge clk) disable iff (rst)
                    iss_lane[gi] |-> !fe_first[gi]);
            end
        end
    endgenerate
endmodule

// File: tb/uop_issue_ctrl_bench.sv
module uop_issue_ctrl_bench;
    localparam int W  = 2;
    localparam int CW = $clog2(W + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stall_i = 1'b0;
    logic [1:0] fe_valid = '0, fe_first = '0, fe_last = '0;
    logic [7:0] fe_uops = '0;
    logic [1:0] fe_take, iss_lane;
    logic held_issued, carry_serviced, busy;
    logic [CW-1:0] cyc_uops;
    logic [3:0] carry_pend;
    logic [15:0] total_uops;

    uop_issue_ctrl #(.ISSUE_W(W), .LANES(2), .CNT_W(16)) u_uop_issue_ctrl (
        .clk(clk), .rst(rst), .stall_i(stall_i),
        .fe_valid(fe_valid), .fe_first(fe_first), .fe_last(fe_last), .fe_uops(fe_uops),
        .fe_take(fe_take), .iss_lane(iss_lane), .held_issued(held_issued),
        .carry_serviced(carry_serviced), .cyc_uops(cyc_uops), .carry_pend(carry_pend),
        .total_uops(total_uops), .busy(busy)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_carry = 0, m_clast = 0, m_sv = 0, m_su = 0, m_sb = 0, m_se = 0, m_total = 0;
    int last_take = 0, last_cyc = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic attempt(input int u, input int b, input int e,
                           inout int bd, inout int fs, output int go, output int iss, output int rem);
        int room;
        go = 0; iss = 0; rem = 0;
        room = (u > W) ? (bd >= 1) : (bd >= u);
        if (room != 0 && (fs != 0 || b == 0)) begin
            go = 1; fs = 0;
            if (u > bd) begin
                iss = bd; rem = u - bd; bd = 0;
            end else begin
                iss = u; bd = (e != 0) ? 0 : bd - u;
            end
        end
    endtask

    task automatic cyc(input int v0, input int v1, input int u0, input int u1,
                       input int b0, input int b1, input int e0, input int e1, input int st);
        int bd, fs, used, cn, cl, svn, tk, go, iss, rem, ok;
        string tag;
        @(negedge clk);
        stall_i  = st[0];
        fe_valid = {v1[0], v0[0]};
        fe_first = {b1[0], b0[0]};
        fe_last  = {e1[0], e0[0]};
        fe_uops  = {u1[3:0], u0[3:0]};
        bd = W; fs = 1; used = 0; cn = 0; cl = m_clast; svn = m_sv; tk = 0;
        if (m_carry > W) begin
            cn = m_carry - W; used = W; bd = 0; fs = 0;
        end else if (m_carry > 0) begin
            used = m_carry; bd = (m_clast != 0) ? 0 : W - m_carry; fs = 0;
        end
        if (m_sv != 0 && st == 0 && cn == 0) begin
            attempt(m_su, m_sb, m_se, bd, fs, go, iss, rem);
            if (go != 0) begin
                used += iss; svn = 0;
                if (rem != 0) begin cn = rem; cl = m_se; end
            end
        end
        if (cn == 0 && svn == 0) begin
            if (st != 0) begin
                if (v0 != 0) begin
                    tk = 1; svn = 1;
                end
            end else begin
                ok = 1;
                for (int i = 0; i < 2; i++) begin
                    int u, b, e, v;
                    u = (i == 0) ? u0 : u1; b = (i == 0) ? b0 : b1;
                    e = (i == 0) ? e0 : e1; v = (i == 0) ? v0 : v1;
                    if (ok != 0 && v != 0) begin
                        attempt(u, b, e, bd, fs, go, iss, rem);
                        if (go != 0) begin
                            tk |= (1 << i); used += iss;
                            if (rem != 0) begin cn = rem; cl = e; end
                        end
                        ok = go;
                    end else ok = 0;
                end
            end
        end
        if (m_carry > W)               tag = "R4";
        else if (m_carry > 0)          tag = "R5";
        else if (m_sv != 0 || st != 0) tag = "R8";
        else if (b0 != 0 || b1 != 0)   tag = "R7";
        else if (e0 != 0 || e1 != 0)   tag = "R6";
        else if (u0 > W)               tag = "R3";
        else                           tag = "R2";
        #2;
        chk({tag, " take"}, int'(fe_take), tk);
        chk("R1 cyc_uops", int'(cyc_uops), used);
        chk("R10 busy", int'(busy), (m_carry != 0 || m_sv != 0) ? 1 : 0);
        chk("R3 carry_pend", int'(carry_pend), m_carry);
        chk("R11 total", int'(total_uops), m_total);
        last_take = int'(fe_take);
        last_cyc  = int'(cyc_uops);
        if (st != 0 && tk[0] == 1'b1) begin
            m_su = u0; m_sb = b0; m_se = e0;
        end
        @(posedge clk);
        m_total = (m_total + used) % 65536;
        m_carry = cn; m_clast = cl; m_sv = svn;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int r;
        repeat (3) @(posedge clk);
        #2;
        chk("R11 reset total", int'(total_uops), 0);
        chk("R10 reset busy", int'(busy), 0);
        @(negedge clk);
        rst = 1'b0;

        // R12: 3-uop instruction followed by 1-uop instructions
        cyc(1, 1, 3, 1, 0, 0, 0, 0, 0);
        chk("R12 first cycle take", last_take, 1);
        chk("R12 first cycle uops", last_cyc, 2);
        cyc(1, 1, 1, 1, 0, 0, 0, 0, 0);
        chk("R12 second cycle take", last_take, 1);
        chk("R12 second cycle uops", last_cyc, 2);
        cyc(0, 0, 1, 1, 0, 0, 0, 0, 0);

        // R9: long remainder blocks intake
        cyc(1, 0, 5, 1, 0, 0, 0, 0, 0);
        cyc(1, 1, 1, 1, 0, 0, 0, 0, 0);
        chk("R9 no intake while carry pending", last_take, 0);
        cyc(1, 1, 1, 1, 0, 0, 0, 0, 0);
        chk("R5 completion leaves one slot", last_take, 1);

        // R8/R9: held instruction blocks intake during stall
        cyc(1, 1, 2, 1, 0, 0, 0, 0, 1);
        cyc(1, 1, 1, 1, 0, 0, 0, 0, 1);
        chk("R9 no intake while held", last_take, 0);
        cyc(1, 1, 1, 1, 0, 0, 0, 0, 0);
        chk("R8 held issues first", last_cyc, 2);

        // exhaustive sweep over lane pairs and flags
        for (int u0 = 1; u0 <= 5; u0++)
            for (int u1 = 1; u1 <= 5; u1++)
                for (int f = 0; f < 16; f++) begin
                    cyc(1, 1, u0, u1, f & 1, (f >> 1) & 1, (f >> 2) & 1, (f >> 3) & 1, 0);
                    cyc(0, 0, 1, 1, 0, 0, 0, 0, 0);
                    cyc(0, 0, 1, 1, 0, 0, 0, 0, 0);
                end

        // pseudo-random traffic with stalls
        r = 12345;
        for (int n = 0; n < 4000; n++) begin
            int a;
            r = (r * 1103515245 + 12345) & 32'h7fffffff;
            a = r >> 4;
            cyc((a % 8) != 0 ? 1 : 0, ((a >> 3) % 4) != 0 ? 1 : 0,
                1 + ((a >> 5) % 5), 1 + ((a >> 8) % 5),
                ((a >> 11) % 6) == 0 ? 1 : 0, ((a >> 14) % 6) == 0 ? 1 : 0,
                ((a >> 17) % 5) == 0 ? 1 : 0, ((a >> 20) % 5) == 0 ? 1 : 0,
                ((a >> 23) % 7) == 0 ? 1 : 0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule